// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

A 4-bit binary counter whose direction is chosen by which of two strobe inputs is pulsed, not by a select pin. Both strobes rest at logic 1. A pulse on the up strobe (the other strobe held at 1) adds one to the count. A pulse on the down strobe (the up strobe held at 1) subtracts one. A synchronous clear returns the count to zero.

The strobes may come from switches or logic in another clock domain. Each strobe passes through its own synchroniser into the system clock domain. A rising-edge detector then turns the strobe's return to 1 into a single-cycle step request. The count wraps in both directions. A step request is dropped when both strobes rise in the same cycle, and clear overrides any step.

Top module: `updn_dual_clk_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0, and it stays 0 after reset until a clear or strobe event changes it.
- R2: A rising edge on cnt_up_i, with cnt_dn_i held at 1, raises count_o by exactly one.
- R3: A rising edge on cnt_dn_i, with cnt_up_i held at 1, lowers count_o by exactly one.
- R4: Counting up from 15 (4'b1111) gives 0.
- R5: Counting down from 0 gives 15 (4'b1111).
- R6: If both strobes rise in the same cycle, count_o does not change.
- R7: clear_i is active high and synchronous: count_o is 0 after the first rising clock edge at which clear_i is sampled high.
- R8: While clear_i is high, a strobe rising edge does not move the count away from 0.
- R9: A falling strobe edge, or a strobe held at a steady level, leaves count_o unchanged.
- R10: count_o[0] is the least significant bit and count_o[3] is the most significant bit, so 0,1,2,...,15 appear as plain binary.
- R11: A strobe driven from 0 to 1 between clock edges changes count_o at the third rising clock edge after that change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear, active high |
| cnt_up_i | input | 1 | Up strobe, idles high, counts on rising edge |
| cnt_dn_i | input | 1 | Down strobe, idles high, counts on rising edge |
| count_o | output | 4 | Count value, bit 0 is the LSB |

## Verification
The hardest case to reach is the two synchronised strobes rising in exactly the same system cycle. Random traffic almost never lines them up. The stimulus therefore includes an operation that lowers both strobes together and releases them at the same negative clock edge, so both pass through identical synchroniser depths. The same directed operations are also aimed at the wrap points and at a clear held across a strobe rise.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_CLR  = 2'd3
  } step_e;

  // clear wins; simultaneous up and down cancel
  function automatic step_e decode_step(logic clr, logic up, logic dn);
    if (clr)            return STEP_CLR;
    else if (up && !dn) return STEP_INC;
    else if (dn && !up) return STEP_DEC;
    else                return STEP_HOLD;
  endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RESET_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/updn_rise.sv
module updn_rise #(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  // reset to idle level so release from reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_VAL;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_e            step_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      unique case (step_i)
        STEP_CLR: count_q <= '0;
        STEP_INC: count_q <= count_q + WIDTH'(1);
        STEP_DEC: count_q <= count_q - WIDTH'(1);
        default:  count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/updn_dual_clk_counter.sv
module updn_dual_clk_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  output logic [WIDTH-1:0] count_o
);

  localparam int NUM_STROBES = 2;
  localparam int UP_IDX      = 0;
  localparam int DN_IDX      = 1;

  logic [NUM_STROBES-1:0] strobe_raw;
  logic [NUM_STROBES-1:0] strobe_sync;
  logic [NUM_STROBES-1:0] strobe_rise;
  logic                   up_rise;
  logic                   dn_rise;
  step_e                  step;

  assign strobe_raw = {cnt_dn_i, cnt_up_i};

  generate
    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
      updn_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
      ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (strobe_raw[g]),
        .q_o    (strobe_sync[g])
      );

      updn_rise #(
        .IDLE_VAL (1'b1)
      ) u_rise (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (strobe_sync[g]),
        .rise_o  (strobe_rise[g])
      );
    end
  endgenerate

  assign up_rise = strobe_rise[UP_IDX];
  assign dn_rise = strobe_rise[DN_IDX];
  assign step    = decode_step(clear_i, up_rise, dn_rise);

  updn_core #(
    .WIDTH (WIDTH)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .count_o (count_o)
  );

endmodule

// File: rtl/updn_counter_checker.sv
module updn_counter_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             up_rise_i,
  input logic             dn_rise_i,
  input logic [WIDTH-1:0] count_i
);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_i == '0);

  assert_clear_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && (up_rise_i || dn_rise_i)) |=> count_i == '0);

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && up_rise_i && !dn_rise_i) |=> count_i == WIDTH'($past(count_i) + 1'b1));

  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && dn_rise_i && !up_rise_i) |=> count_i == WIDTH'($past(count_i) - 1'b1));

  assert_both_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && up_rise_i && dn_rise_i) |=> $stable(count_i));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !up_rise_i && !dn_rise_i) |=> $stable(count_i));

  assert_wrap_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && up_rise_i && !dn_rise_i && count_i == '1) |=> count_i == '0);

  assert_wrap_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && dn_rise_i && !up_rise_i && count_i == '0) |=> count_i == '1);

endmodule

bind updn_dual_clk_counter updn_counter_checker #(
  .WIDTH (WIDTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .up_rise_i (up_rise),
  .dn_rise_i (dn_rise),
  .count_i   (count_o)
);

// File: tb/updn_dual_clk_counter_tb.sv
module updn_dual_clk_counter_tb;

  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         clear_i;
  logic         cnt_up_i;
  logic         cnt_dn_i;
  logic [W-1:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int model  = 0;

  always #4ns clk_i = ~clk_i;

  updn_dual_clk_counter u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .cnt_up_i (cnt_up_i),
    .cnt_dn_i (cnt_dn_i),
    .count_o  (count_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // op: 0 up, 1 down, 2 both, 3 clear, 4 clear during up rise
  function automatic int next_count(int c, int op);
    case (op)
      0: return (c + 1) % 16;
      1: return (c + 15) % 16;
      2: return c;
      default: return 0;
    endcase
  endfunction

  task automatic do_op(int op, string req);
    case (op)
      0, 1, 2: begin
        if (op != 1) cnt_up_i = 1'b0;
        if (op != 0) cnt_dn_i = 1'b0;
        tick(4);
        check({req, " fall no effect R9"}, int'(count_o), model);
        cnt_up_i = 1'b1;
        cnt_dn_i = 1'b1;
        tick(4);
      end
      3: begin
        clear_i = 1'b1;
        tick(1);
        clear_i = 1'b0;
        tick(1);
      end
      default: begin
        clear_i  = 1'b1;
        cnt_up_i = 1'b0;
        tick(4);
        cnt_up_i = 1'b1;
        tick(4);
        clear_i = 1'b0;
        tick(2);
      end
    endcase
    model = next_count(model, op);
    check(req, int'(count_o), model);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk_i);
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_ni   = 1'b0;
    clear_i  = 1'b0;
    cnt_up_i = 1'b1;
    cnt_dn_i = 1'b1;
    void'($urandom(32'd2024));
    tick(3);
    check("R1 in reset", int'(count_o), 0);
    rst_ni = 1'b1;
    tick(3);
    check("R1 after reset", int'(count_o), 0);

    // R11 latency
    cnt_up_i = 1'b0;
    tick(4);
    cnt_up_i = 1'b1;
    tick(2);
    check("R11 no change at 2nd edge", int'(count_o), 0);
    tick(1);
    check("R11 change at 3rd edge", int'(count_o), 1);
    model = 1;
    tick(3);
    check("R9 steady high", int'(count_o), 1);

    // R2 / R10 / R4: walk up through wrap
    for (int i = 0; i < 16; i++) begin
      do_op(0, (model == 15) ? "R4 wrap up" : "R2 R10 up step");
    end
    // R3 / R5: walk down through wrap
    do_op(3, "R7 clear");
    do_op(1, "R5 wrap down");
    for (int i = 0; i < 5; i++) do_op(1, "R3 down step");
    do_op(2, "R6 both rise");
    do_op(4, "R8 clear priority");
    do_op(1, "R5 wrap down again");
    do_op(2, "R6 both rise at 15");

    // R10 explicit bit weights
    do_op(3, "R7 clear");
    for (int i = 0; i < 5; i++) do_op(0, "R2 up step");
    check("R10 bit0", int'(count_o[0]), 1);
    check("R10 bit2", int'(count_o[2]), 1);
    check("R10 bit3", int'(count_o[3]), 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      int r;
      int op;
      r = int'($urandom_range(0, 19));
      if (r < 8)       op = 0;
      else if (r < 15) op = 1;
      else if (r < 18) op = 2;
      else if (r < 19) op = 3;
      else             op = 4;
      do_op(op, "R2 R3 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule